// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Switching Network

This block connects N = 2^n source ports to N destination ports through n columns of two-by-two switching cells, with no central scheduler. Ahead of every column sits a fixed perfect-shuffle wiring that rotates each line index left by one bit. A request consists of a valid flag, a destination tag holding the binary number of the wanted output port, and a payload. Each cell reads one tag bit, the most significant bit in the first column down to the least significant bit in the last, and steers the request to its upper output for a 0 or its lower output for a 1.

When both inputs of a cell want the same output, the cell grants one of them in round-robin order and drops the other. The result is registered once after the final column. One cycle after a request, each destination port shows what arrived and which source sent it, and each source sees either an accept or a reject flag. Rejected sources are expected to retry. No storage exists inside the cells.

Top module: `omega_network`

## Requirements
- R1: A request presented on source s with tag d and accepted appears one clock later on output port d with out_valid set, its payload unchanged and out_src equal to s.
- R2: One clock after a cycle in which source s had in_valid high, exactly one of in_accept[s] and in_reject[s] is high. For a source that was idle, both are low.
- R3: Every uniform cyclic-shift pattern, where source i targets port (i + k) mod N for all i, is delivered with every request accepted and none rejected.
- R4: A request that meets no other valid request in any cell it crosses passes without arbitration and is always accepted.
- R5: When two requests meet in a cell and need the same cell output, exactly one is delivered and the other is rejected. The number of accepted sources always equals the number of valid output ports.
- R6: Each cell holds a one-bit round-robin pointer. Reset sets it to favour the cell's upper input, and each conflict in that cell flips it. With the default size, sources 0 and 1 both targeting port 5 meet in the last column, and repeated attempts are won by source 0, then 1, then 0.
- R7: The tag's most significant bit steers the first column. With the default size, sources 0 and 4 share a first-column cell, so tags 4 and 6 (both with MSB 1) conflict there. After reset, source 0 wins and is delivered to port 4, and source 4 is rejected.
- R8: While reset is high, out_valid, in_accept and in_reject are all low, and out_src and out_data are zero.
- R9: A cycle with no valid request produces no valid output and no accept or reject flag on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_PORTS | Request present, one bit per source |
| in_tag | input | N_PORTS*TAG_W | Destination port number per source, source i at bits [i*TAG_W +: TAG_W] |
| in_data | input | N_PORTS*DATA_W | Payload per source, source i at bits [i*DATA_W +: DATA_W] |
| out_valid | output | N_PORTS | Registered: a payload arrived at this destination |
| out_src | output | N_PORTS*TAG_W | Registered: source number of the payload at each destination |
| out_data | output | N_PORTS*DATA_W | Registered: payload at each destination |
| in_accept | output | N_PORTS | Registered: the previous cycle's request from this source was delivered |
| in_reject | output | N_PORTS | Registered: the previous cycle's request from this source was dropped |

## Verification
On every cycle the checker confirms several properties. Each valid output carries a payload that was sent one cycle earlier by a source whose tag names that port. Every earlier request gets exactly one of accept or reject. The accept count matches the count of valid outputs. A lone request is always accepted, and a cycle with no requests yields nothing. Which source wins a given conflict depends on the pointer history of one particular cell, so only the bench's directed scenarios can show it. Those scenarios cover the alternating winners in the last column, the first-column collision decided by the tag's top bit, and the full delivery of cyclic-shift patterns.

// File: rtl/omega_pkg.sv
package omega_pkg;

    // Which output of a 2x2 cell a request leaves on; also the round-robin favourite.
    typedef enum logic {
        SIDE_UPPER = 1'b0,
        SIDE_LOWER = 1'b1
    } side_e;

    // Perfect shuffle: rotate a line index of 'bits' bits left by one.
    function automatic int shuffle_pos(input int idx, input int bits);
        int mask;
        mask = (1 << bits) - 1;
        return ((idx << 1) | (idx >> (bits - 1))) & mask;
    endfunction

    function automatic side_e flip_side(input side_e s);
        return (s == SIDE_UPPER) ? SIDE_LOWER : SIDE_UPPER;
    endfunction

endpackage

// File: rtl/omega_switch2.sv
module omega_switch2
    import omega_pkg::*;
#(
    parameter int TAG_W     = 3,
    parameter int DATA_W    = 8,
    parameter int STEER_BIT = 0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [1+2*TAG_W+DATA_W-1:0]  in_up,
    input  logic [1+2*TAG_W+DATA_W-1:0]  in_low,
    output logic [1+2*TAG_W+DATA_W-1:0]  out_up,
    output logic [1+2*TAG_W+DATA_W-1:0]  out_low
);
    localparam int LINE_W  = 1 + 2 * TAG_W + DATA_W;
    localparam int VALID_B = LINE_W - 1;
    localparam int TAG_LSB = DATA_W + TAG_W;

    side_e rr_q;
    side_e up_dir, low_dir;
    logic  up_v, low_v, clash, up_win, low_win;

    always_comb begin
        up_v    = in_up[VALID_B];
        low_v   = in_low[VALID_B];
        up_dir  = side_e'(in_up[TAG_LSB + STEER_BIT]);
        low_dir = side_e'(in_low[TAG_LSB + STEER_BIT]);
        clash   = up_v && low_v && (up_dir == low_dir);
        up_win  = up_v  && (!clash || (rr_q == SIDE_UPPER));
        low_win = low_v && (!clash || (rr_q == SIDE_LOWER));

        out_up  = '0;
        out_low = '0;
        if (up_win  && up_dir  == SIDE_UPPER) out_up  = in_up;
        if (low_win && low_dir == SIDE_UPPER) out_up  = in_low;
        if (up_win  && up_dir  == SIDE_LOWER) out_low = in_up;
        if (low_win && low_dir == SIDE_LOWER) out_low = in_low;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= SIDE_UPPER;
        end else if (clash) begin
            rr_q <= flip_side(rr_q);
        end
    end

endmodule

// File: rtl/omega_stage.sv
module omega_stage
    import omega_pkg::*;
#(
    parameter int N_PORTS   = 8,
    parameter int TAG_W     = 3,
    parameter int DATA_W    = 8,
    parameter int STEER_BIT = 0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [1+2*TAG_W+DATA_W-1:0]  in_lines  [N_PORTS],
    output logic [1+2*TAG_W+DATA_W-1:0]  out_lines [N_PORTS]
);
    localparam int LINE_W = 1 + 2 * TAG_W + DATA_W;
    localparam int CELLS  = N_PORTS / 2;

    logic [LINE_W-1:0] shuf [N_PORTS];

    // Fixed shuffle wiring ahead of the cell column.
    for (genvar i = 0; i < N_PORTS; i++) begin : g_shuffle
        localparam int DST = shuffle_pos(i, TAG_W);
        assign shuf[DST] = in_lines[i];
    end

    for (genvar j = 0; j < CELLS; j++) begin : g_cell
        omega_switch2 #(
            .TAG_W    (TAG_W),
            .DATA_W   (DATA_W),
            .STEER_BIT(STEER_BIT)
        ) u_cell (
            .clk    (clk),
            .rst    (rst),
            .in_up  (shuf[2*j]),
            .in_low (shuf[2*j+1]),
            .out_up (out_lines[2*j]),
            .out_low(out_lines[2*j+1])
        );
    end

endmodule

// File: rtl/omega_network.sv
module omega_network
    import omega_pkg::*;
#(
    parameter int N_PORTS = 8,
    parameter int DATA_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_PORTS-1:0]            in_valid,
    input  logic [N_PORTS*$clog2(N_PORTS)-1:0] in_tag,
    input  logic [N_PORTS*DATA_W-1:0]     in_data,
    output logic [N_PORTS-1:0]            out_valid,
    output logic [N_PORTS*$clog2(N_PORTS)-1:0] out_src,
    output logic [N_PORTS*DATA_W-1:0]     out_data,
    output logic [N_PORTS-1:0]            in_accept,
    output logic [N_PORTS-1:0]            in_reject
);
    localparam int TAG_W   = $clog2(N_PORTS);
    localparam int STAGES  = TAG_W;
    localparam int LINE_W  = 1 + 2 * TAG_W + DATA_W;
    localparam int VALID_B = LINE_W - 1;

    logic [LINE_W-1:0]  lanes [STAGES+1][N_PORTS];
    logic [N_PORTS-1:0] delivered;

    // Build the line bundle: {valid, tag, source, payload}.
    for (genvar i = 0; i < N_PORTS; i++) begin : g_entry
        assign lanes[0][i] = {in_valid[i], in_tag[i*TAG_W +: TAG_W],
                              TAG_W'(i), in_data[i*DATA_W +: DATA_W]};
    end

    // Column s steers on tag bit STAGES-1-s: MSB first.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        omega_stage #(
            .N_PORTS  (N_PORTS),
            .TAG_W    (TAG_W),
            .DATA_W   (DATA_W),
            .STEER_BIT(STAGES - 1 - s)
        ) u_stage (
            .clk      (clk),
            .rst      (rst),
            .in_lines (lanes[s]),
            .out_lines(lanes[s+1])
        );
    end

    always_comb begin
        delivered = '0;
        for (int d = 0; d < N_PORTS; d++) begin
            for (int s = 0; s < N_PORTS; s++) begin
                if (lanes[STAGES][d][VALID_B] &&
                    lanes[STAGES][d][DATA_W +: TAG_W] == TAG_W'(s)) begin
                    delivered[s] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= '0;
            out_src   <= '0;
            out_data  <= '0;
            in_accept <= '0;
            in_reject <= '0;
        end else begin
            for (int d = 0; d < N_PORTS; d++) begin
                out_valid[d]                   <= lanes[STAGES][d][VALID_B];
                out_src[d*TAG_W +: TAG_W]      <= lanes[STAGES][d][DATA_W +: TAG_W];
                out_data[d*DATA_W +: DATA_W]   <= lanes[STAGES][d][DATA_W-1:0];
            end
            in_accept <= delivered;
            in_reject <= in_valid & ~delivered;
        end
    end

endmodule

// File: rtl/omega_network_chk.sv
module omega_network_chk #(
    parameter int N_PORTS = 8,
    parameter int DATA_W  = 8
) (
    input logic                               clk,
    input logic                               rst,
    input logic [N_PORTS-1:0]                 in_valid,
    input logic [N_PORTS*$clog2(N_PORTS)-1:0] in_tag,
    input logic [N_PORTS*DATA_W-1:0]          in_data,
    input logic [N_PORTS-1:0]                 out_valid,
    input logic [N_PORTS*$clog2(N_PORTS)-1:0] out_src,
    input logic [N_PORTS*DATA_W-1:0]          out_data,
    input logic [N_PORTS-1:0]                 in_accept,
    input logic [N_PORTS-1:0]                 in_reject
);
    localparam int TAG_W = $clog2(N_PORTS);

    logic                        armed;
    logic [N_PORTS-1:0]          prev_valid;
    logic [N_PORTS*TAG_W-1:0]    prev_tag;
    logic [N_PORTS*DATA_W-1:0]   prev_data;
    logic [N_PORTS-1:0]          dest_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed      <= 1'b0;
            prev_valid <= '0;
            prev_tag   <= '0;
            prev_data  <= '0;
        end else begin
            armed      <= 1'b1;
            prev_valid <= in_valid;
            prev_tag   <= in_tag;
            prev_data  <= in_data;
        end
    end

    always_comb begin
        for (int d = 0; d < N_PORTS; d++) begin
            int src;
            src = int'(out_src[d*TAG_W +: TAG_W]);
            dest_ok[d] = prev_valid[src] && in_accept[src] &&
                         (prev_tag[src*TAG_W +: TAG_W] == TAG_W'(d)) &&
                         (prev_data[src*DATA_W +: DATA_W] == out_data[d*DATA_W +: DATA_W]);
        end
    end

    // R1: every delivered payload came from a source whose tag names this port.
    for (genvar d = 0; d < N_PORTS; d++) begin : g_dest
        assert_dest_R1: assert property (@(posedge clk) disable iff (rst)
            (armed && out_valid[d]) |-> dest_ok[d]);
    end

    // R2: each earlier request gets exactly one verdict, idle sources none.
    assert_verdict_R2: assert property (@(posedge clk) disable iff (rst)
        armed |-> (((in_accept | in_reject) == prev_valid) && ((in_accept & in_reject) == '0)));

    // R4: a single request in the whole network meets no partner and is accepted.
    assert_lone_R4: assert property (@(posedge clk) disable iff (rst)
        (armed && $countones(prev_valid) == 1) |-> (in_accept == prev_valid));

    // R5: accepted sources and occupied outputs agree in number.
    assert_count_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(in_accept) == $countones(out_valid));

    // R9: no requests in, nothing out.
    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (armed && prev_valid == '0) |-> (out_valid == '0 && in_accept == '0 && in_reject == '0));

endmodule

bind omega_network omega_network_chk #(
    .N_PORTS(N_PORTS),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_tag   (in_tag),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_src  (out_src),
    .out_data (out_data),
    .in_accept(in_accept),
    .in_reject(in_reject)
);

// File: tb/omega_network_tb.sv
`timescale 1ns/1ps
module omega_network_tb;
    localparam int N  = 8;
    localparam int TW = 3;
    localparam int DW = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    in_valid = '0;
    logic [N*TW-1:0] in_tag = '0;
    logic [N*DW-1:0] in_data = '0;
    logic [N-1:0]    out_valid;
    logic [N*TW-1:0] out_src;
    logic [N*DW-1:0] out_data;
    logic [N-1:0]    in_accept;
    logic [N-1:0]    in_reject;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    omega_network #(.N_PORTS(N), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag), .in_data(in_data),
        .out_valid(out_valid), .out_src(out_src), .out_data(out_data),
        .in_accept(in_accept), .in_reject(in_reject)
    );

    // Conflict-free vectors: {valid mask, tags of sources 7..0}.
    localparam logic [31:0] VECS [4] = '{
        {8'hFF, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0},  // shift 0
        {8'hFF, 3'd0, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1},  // shift 1
        {8'hFF, 3'd2, 3'd1, 3'd0, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3},  // shift 3
        {8'h55, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0}   // half load
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [N-1:0] v, input logic [N*TW-1:0] t, input logic [N*DW-1:0] d);
        in_valid = v;
        in_tag   = t;
        in_data  = d;
        @(negedge clk);
    endtask

    task automatic set_tag(inout logic [N*TW-1:0] t, input int src, input int dst);
        t[src*TW +: TW] = TW'(dst);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [N*TW-1:0] t;
        logic [N*DW-1:0] d;

        // R8: reset state
        repeat (3) @(negedge clk);
        check("R8 out_valid", 64'(out_valid), 64'h0);
        check("R8 accept/reject", 64'({in_accept, in_reject}), 64'h0);
        check("R8 out_data", 64'(out_data), 64'h0);
        rst = 1'b0;

        // R9: idle cycle
        drive('0, '0, '0);
        check("R9 idle outputs", 64'({out_valid, in_accept, in_reject}), 64'h0);

        // R4: lone request, source 3 to port 6
        t = '0; d = '0;
        set_tag(t, 3, 6);
        d[3*DW +: DW] = 8'h3C;
        drive(8'h08, t, d);
        check("R4 out_valid", 64'(out_valid), 64'h40);
        check("R4 out_data", 64'(out_data[6*DW +: DW]), 64'h3C);
        check("R4 accept/reject", 64'({in_accept, in_reject}), {48'h0, 8'h08, 8'h00});

        // R7: sources 0 and 4 meet in first column (tags 4 and 6, MSB both 1)
        t = '0; d = '0;
        set_tag(t, 0, 4); set_tag(t, 4, 6);
        d[0*DW +: DW] = 8'hA0; d[4*DW +: DW] = 8'hA4;
        drive(8'h11, t, d);
        check("R7 accept/reject", 64'({in_accept, in_reject}), {48'h0, 8'h01, 8'h10});
        check("R7 out_valid", 64'(out_valid), 64'h10);
        check("R7 out_src", 64'(out_src[4*TW +: TW]), 64'd0);
        check("R7 out_data", 64'(out_data[4*DW +: DW]), 64'hA0);

        // R6/R5: sources 0 and 1 both to port 5, winners alternate 0,1,0
        t = '0; d = '0;
        set_tag(t, 0, 5); set_tag(t, 1, 5);
        d[0*DW +: DW] = 8'hB0; d[1*DW +: DW] = 8'hB1;
        for (int k = 0; k < 3; k++) begin
            int win;
            win = (k % 2 == 0) ? 0 : 1;
            drive(8'h03, t, d);
            check("R6 accept", 64'(in_accept), 64'(1 << win));
            check("R5 reject", 64'(in_reject), 64'(1 << (1 - win)));
            check("R6 out_src", 64'(out_src[5*TW +: TW]), 64'(win));
            check("R5 out_valid", 64'(out_valid), 64'h20);
        end

        // R3/R1/R2: conflict-free table
        for (int v = 0; v < 4; v++) begin
            logic [N-1:0] vm;
            logic [N-1:0] exp_ov;
            vm = VECS[v][31:24];
            t  = VECS[v][23:0];
            for (int i = 0; i < N; i++) d[i*DW +: DW] = DW'(v * 16 + i);
            drive(vm, t, d);
            exp_ov = '0;
            for (int i = 0; i < N; i++) begin
                if (vm[i]) begin
                    int dst;
                    dst = int'(t[i*TW +: TW]);
                    exp_ov[dst] = 1'b1;
                    check("R1 out_src", 64'(out_src[dst*TW +: TW]), 64'(i));
                    check("R1 out_data", 64'(out_data[dst*DW +: DW]), 64'(d[i*DW +: DW]));
                end
            end
            check("R1 out_valid", 64'(out_valid), 64'(exp_ov));
            check("R3 accept", 64'(in_accept), 64'(vm));
            check("R2 reject", 64'(in_reject), 64'h0);
        end

        // R9: back to idle
        drive('0, '0, '0);
        check("R9 idle after load", 64'({out_valid, in_accept, in_reject}), 64'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule